// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec (8-bit message, 12-bit codeword)

The block protects an 8-bit message with 4 check bits. It has two independent datapaths that share one clock. The encode path spreads the message across a 12-bit codeword and fills the check positions so that every parity group is even.

The decode path recomputes the four group parities of a received word. The resulting syndrome is the 1-based position of a single flipped bit. The decoder inverts that bit, extracts the message and raises a flag. A syndrome outside the codeword range cannot come from a single error, so the word is reported as uncorrectable and its data bits are passed through as received.

Both paths register their outputs. Each result appears one cycle after its input valid. The output registers keep their contents while the input valid is low.

Top module: `ham12_codec`

## Requirements
- R1: Codeword bit p-1 holds position p (p = 1..12). Check bits sit at positions 1, 2, 4 and 8. Message bit k (msg[k-1], k = 1..8) sits at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order.
- R2: Every check bit at position 2^i makes the XOR of all positions whose index has bit i set equal to zero. For example, message 0xE3 encodes to codeword 0xE97.
- R3: enc_valid_o is enc_valid_i delayed by one cycle, and enc_code_o is the codeword of the message accepted in that cycle. While enc_valid_i is low, enc_valid_o goes low on the next cycle and enc_code_o keeps its value.
- R4: A received word with syndrome zero yields its own data bits on dec_msg_o, with dec_fixed_o = 0 and dec_bad_o = 0.
- R5: A word with exactly one bit inverted, at any of the 12 positions (check or data), yields the original message with dec_fixed_o = 1 and dec_bad_o = 0.
- R6: A syndrome of 13, 14 or 15 sets dec_bad_o = 1 and dec_fixed_o = 0. In that case dec_msg_o carries the received data bits unchanged. The two flags are never high together.
- R7: dec_valid_o is dec_valid_i delayed by one cycle. While dec_valid_i is low, dec_valid_o goes low on the next cycle, and dec_msg_o and both flags keep their values.
- R8: A synchronous active-high reset clears both output valids, the codeword, the message and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Message present on enc_msg_i |
| enc_msg_i | input | 8 | Message to encode, bit k-1 = message bit k |
| enc_valid_o | output | 1 | Codeword output valid |
| enc_code_o | output | 12 | Encoded word, bit p-1 = position p |
| dec_valid_i | input | 1 | Received word present on dec_code_i |
| dec_code_i | input | 12 | Received word, bit p-1 = position p |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_msg_o | output | 8 | Corrected (or passed-through) message |
| dec_fixed_o | output | 1 | A single-bit error was corrected |
| dec_bad_o | output | 1 | Syndrome outside 1..12, data not corrected |

## Verification
The bench inverts each of the 12 positions in turn, including the four check positions. A decoder that mis-indexed its flip would corrupt a data bit there, and one that ignored check-bit errors would leave the flag low. It forces double errors whose syndromes are 13, 14 and 15. A decoder without a range check would index past the word or corrupt data, and the bench expects the unchanged received data with only the bad flag set. Idle cycles between transactions show whether the outputs hold and the valids drop. Random messages with a random error position compare against a model that forms the syndrome as the XOR of the indices of the set bits.

// File: rtl/ham_pkg.sv
package ham_pkg;

  typedef enum logic [1:0] {
    DEC_CLEAN = 2'd0,
    DEC_FIXED = 2'd1,
    DEC_BAD   = 2'd2
  } dec_stat_e;

  // True when p is a nonzero power of two (a check position).
  function automatic bit is_pow2(input int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // 1-based codeword position of the k-th (0-based) message bit.
  function automatic int data_pos(input int k);
    int cnt;
    int pos;
    cnt = -1;
    pos = 0;
    for (int p = 1; p < 256; p++) begin
      if (!is_pow2(p)) begin
        cnt++;
        if (cnt == k && pos == 0) pos = p;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/ham_enc_core.sv
module ham_enc_core #(
  parameter int MSG_W = 8,
  parameter int CHK_W = 4
) (
  input  logic [MSG_W-1:0]       msg,
  output logic [MSG_W+CHK_W-1:0] code
);
  import ham_pkg::*;
  localparam int CODE_W = MSG_W + CHK_W;

  function automatic logic [CODE_W-1:0] group_mask(input int i);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (((p >> i) & 1) == 1 && !is_pow2(p)) m[p-1] = 1'b1;
    return m;
  endfunction

  logic [CODE_W-1:0] placed;
  logic [CHK_W-1:0]  chk;

  // Check positions of the placed vector stay zero.
  always_comb begin
    placed = '0;
    for (int k = 0; k < MSG_W; k++)
      placed[data_pos(k)-1] = msg[k];
  end

  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    localparam logic [CODE_W-1:0] MASK = group_mask(i);
    assign chk[i] = ^(placed & MASK);
  end

  always_comb begin
    code = placed;
    for (int i = 0; i < CHK_W; i++)
      code[(1 << i) - 1] = chk[i];
  end

endmodule

// File: rtl/ham_syn_core.sv
module ham_syn_core #(
  parameter int MSG_W = 8,
  parameter int CHK_W = 4
) (
  input  logic [MSG_W+CHK_W-1:0] code,
  output logic [CHK_W-1:0]       syn
);
  localparam int CODE_W = MSG_W + CHK_W;

  // Full group, check position included.
  function automatic logic [CODE_W-1:0] full_mask(input int i);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (((p >> i) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

  for (genvar i = 0; i < CHK_W; i++) begin : g_syn
    localparam logic [CODE_W-1:0] MASK = full_mask(i);
    assign syn[i] = ^(code & MASK);
  end

endmodule

// File: rtl/ham_fix_core.sv
module ham_fix_core #(
  parameter int MSG_W = 8,
  parameter int CHK_W = 4
) (
  input  logic [MSG_W+CHK_W-1:0] code,
  input  logic [CHK_W-1:0]       syn,
  output logic [MSG_W-1:0]       msg,
  output ham_pkg::dec_stat_e     stat
);
  import ham_pkg::*;
  localparam int CODE_W = MSG_W + CHK_W;
  localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] repaired;

  always_comb begin
    repaired = code;
    stat     = DEC_CLEAN;
    if (syn != '0) begin
      if (int'(syn) <= CODE_W) begin
        repaired = code ^ (ONE << (syn - 1'b1));
        stat     = DEC_FIXED;
      end else begin
        stat     = DEC_BAD;
      end
    end
  end

  for (genvar k = 0; k < MSG_W; k++) begin : g_ext
    localparam int POS = data_pos(k);
    assign msg[k] = repaired[POS-1];
  end

endmodule

// File: rtl/ham12_codec.sv
module ham12_codec #(
  parameter int MSG_W = 8,
  parameter int CHK_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enc_valid_i,
  input  logic [MSG_W-1:0]       enc_msg_i,
  output logic                   enc_valid_o,
  output logic [MSG_W+CHK_W-1:0] enc_code_o,
  input  logic                   dec_valid_i,
  input  logic [MSG_W+CHK_W-1:0] dec_code_i,
  output logic                   dec_valid_o,
  output logic [MSG_W-1:0]       dec_msg_o,
  output logic                   dec_fixed_o,
  output logic                   dec_bad_o
);
  import ham_pkg::*;
  localparam int CODE_W = MSG_W + CHK_W;

  logic [CODE_W-1:0] enc_word;
  logic [CHK_W-1:0]  dec_syn;
  logic [MSG_W-1:0]  dec_word;
  dec_stat_e         dec_stat;

  ham_enc_core #(.MSG_W(MSG_W), .CHK_W(CHK_W)) enc_i (
    .msg  (enc_msg_i),
    .code (enc_word)
  );

  ham_syn_core #(.MSG_W(MSG_W), .CHK_W(CHK_W)) syn_i (
    .code (dec_code_i),
    .syn  (dec_syn)
  );

  ham_fix_core #(.MSG_W(MSG_W), .CHK_W(CHK_W)) fix_i (
    .code (dec_code_i),
    .syn  (dec_syn),
    .msg  (dec_word),
    .stat (dec_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o <= 1'b0;
      dec_msg_o   <= '0;
      dec_fixed_o <= 1'b0;
      dec_bad_o   <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_msg_o   <= dec_word;
        dec_fixed_o <= (dec_stat == DEC_FIXED);
        dec_bad_o   <= (dec_stat == DEC_BAD);
      end
    end
  end

endmodule

// File: rtl/ham12_codec_chk.sv
module ham12_codec_chk #(
  parameter int MSG_W = 8,
  parameter int CHK_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   enc_valid_i,
  input logic                   enc_valid_o,
  input logic [MSG_W+CHK_W-1:0] enc_code_o,
  input logic                   dec_valid_i,
  input logic [MSG_W+CHK_W-1:0] dec_code_i,
  input logic                   dec_valid_o,
  input logic [MSG_W-1:0]       dec_msg_o,
  input logic                   dec_fixed_o,
  input logic                   dec_bad_o
);
  localparam int CODE_W = MSG_W + CHK_W;

  // Syndrome as XOR of the indices of all set bits.
  function automatic logic [CHK_W-1:0] xsyn(input logic [CODE_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (c[p-1]) s = s ^ CHK_W'(p);
    return s;
  endfunction

  logic [CHK_W-1:0] in_syn;
  assign in_syn = xsyn(dec_code_i);

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> !enc_valid_o && !dec_valid_o && !dec_fixed_o && !dec_bad_o); // R8
  AST_ENC_EVEN: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> (xsyn(enc_code_o) == '0)); // R2
  AST_ENC_LAT: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o); // R3
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_i |=> !enc_valid_o && $stable(enc_code_o)); // R3
  AST_DEC_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && in_syn == '0) |=> dec_valid_o && !dec_fixed_o && !dec_bad_o); // R4
  AST_DEC_FIX: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && in_syn != '0 && int'(in_syn) <= CODE_W) |=> dec_fixed_o && !dec_bad_o); // R5
  AST_DEC_BAD: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && int'(in_syn) > CODE_W) |=> dec_bad_o && !dec_fixed_o); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dec_fixed_o && dec_bad_o)); // R6
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o && $stable(dec_msg_o) && $stable(dec_fixed_o)
                     && $stable(dec_bad_o)); // R7

endmodule

bind ham12_codec ham12_codec_chk #(.MSG_W(MSG_W), .CHK_W(CHK_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .enc_valid_i (enc_valid_i),
  .enc_valid_o (enc_valid_o),
  .enc_code_o  (enc_code_o),
  .dec_valid_i (dec_valid_i),
  .dec_code_i  (dec_code_i),
  .dec_valid_o (dec_valid_o),
  .dec_msg_o   (dec_msg_o),
  .dec_fixed_o (dec_fixed_o),
  .dec_bad_o   (dec_bad_o)
);

// File: tb/ham12_codec_tb_top.sv
`timescale 1ns/1ps
module ham12_codec_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_valid_i = 1'b0;
  logic [7:0]  enc_msg_i = '0;
  logic        enc_valid_o;
  logic [11:0] enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [11:0] dec_code_i = '0;
  logic        dec_valid_o;
  logic [7:0]  dec_msg_o;
  logic        dec_fixed_o;
  logic        dec_bad_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ham12_codec dut_i (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_msg_i(enc_msg_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_msg_o(dec_msg_o),
    .dec_fixed_o(dec_fixed_o), .dec_bad_o(dec_bad_o)
  );

  // Message bit k-1 goes to position DPOS[k-1] (R1).
  function automatic int dpos(input int k);
    case (k)
      0: return 3;  1: return 5;  2: return 6;   3: return 7;
      4: return 9;  5: return 10; 6: return 11;  default: return 12;
    endcase
  endfunction

  function automatic logic [11:0] m_enc(input logic [7:0] m);
    logic [11:0] c;
    logic [3:0]  x;
    c = '0;
    x = '0;
    for (int k = 0; k < 8; k++) begin
      c[dpos(k)-1] = m[k];
      if (m[k]) x = x ^ 4'(dpos(k));
    end
    c[0] = x[0]; c[1] = x[1]; c[3] = x[2]; c[7] = x[3];
    return c;
  endfunction

  function automatic logic [3:0] m_syn(input logic [11:0] c);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= 12; p++) if (c[p-1]) s = s ^ 4'(p);
    return s;
  endfunction

  function automatic logic [7:0] m_data(input logic [11:0] c);
    logic [7:0] m;
    for (int k = 0; k < 8; k++) m[k] = c[dpos(k)-1];
    return m;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // One transaction on both paths; results checked one cycle later.
  task automatic step(input logic [7:0] m, input logic [11:0] rx, input string req);
    logic [3:0]  s;
    logic [11:0] fixed;
    bit          exp_fix, exp_bad;
    s = m_syn(rx);
    fixed = rx;
    exp_fix = 1'b0;
    exp_bad = 1'b0;
    if (s != 0 && s <= 12) begin
      fixed[s-1] = ~fixed[s-1];
      exp_fix = 1'b1;
    end else if (s > 12) begin
      exp_bad = 1'b1;
    end
    @(negedge clk);
    enc_valid_i = 1'b1; enc_msg_i = m;
    dec_valid_i = 1'b1; dec_code_i = rx;
    @(negedge clk);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    check("R3", "enc_valid_o", 32'(enc_valid_o), 32'd1);
    check("R2", "enc_code_o", 32'(enc_code_o), 32'(m_enc(m)));
    check("R7", "dec_valid_o", 32'(dec_valid_o), 32'd1);
    check(req, "dec_msg_o", 32'(dec_msg_o), 32'(m_data(fixed)));
    check(req, "dec_fixed_o", 32'(dec_fixed_o), 32'(exp_fix));
    check(req, "dec_bad_o", 32'(dec_bad_o), 32'(exp_bad));
  endtask

  // Idle cycle with changed inputs: valids drop and data holds (R3, R7).
  task automatic idle_check();
    logic [11:0] c0;
    logic [7:0]  m0;
    logic        f0, b0;
    c0 = enc_code_o; m0 = dec_msg_o; f0 = dec_fixed_o; b0 = dec_bad_o;
    enc_msg_i = ~enc_msg_i;
    dec_code_i = dec_code_i ^ 12'h801;
    @(negedge clk);
    check("R3", "enc_valid_o idle", 32'(enc_valid_o), 32'd0);
    check("R3", "enc_code_o hold", 32'(enc_code_o), 32'(c0));
    check("R7", "dec_valid_o idle", 32'(dec_valid_o), 32'd0);
    check("R7", "dec_msg_o hold", 32'(dec_msg_o), 32'(m0));
    check("R7", "flags hold", 32'({dec_fixed_o, dec_bad_o}), 32'({f0, b0}));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] base;
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(negedge clk);
    enc_valid_i = 1'b1; dec_valid_i = 1'b1;
    enc_msg_i = 8'hA5; dec_code_i = 12'hFFF;
    @(negedge clk);
    check("R8", "enc_valid_o reset", 32'(enc_valid_o), 32'd0);
    check("R8", "enc_code_o reset", 32'(enc_code_o), 32'd0);
    check("R8", "dec_valid_o reset", 32'(dec_valid_o), 32'd0);
    check("R8", "dec outputs reset", 32'({dec_msg_o, dec_fixed_o, dec_bad_o}), 32'd0);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    rst = 1'b0;

    // R1 / R2 worked example: 0xE3 -> 0xE97.
    step(8'hE3, 12'hE97, "R4");
    check("R1", "example codeword", 32'(enc_code_o), 32'h E97);
    idle_check();

    // R5: every single-bit error on the example word.
    for (int p = 1; p <= 12; p++) begin
      base = 12'hE97;
      base[p-1] = ~base[p-1];
      step(8'hE3, base, "R5");
      check("R5", "corrected example", 32'(dec_msg_o), 32'hE3);
    end

    // R6: double errors with syndromes 13, 14, 15; data passes through.
    step(8'hE3, 12'hE97 ^ 12'h801, "R6");
    check("R6", "syn13 passthrough", 32'(dec_msg_o), 32'h63);
    step(8'h00, m_enc(8'h00) ^ 12'h802, "R6");
    check("R6", "syn14 bad", 32'(dec_bad_o), 32'd1);
    step(8'hFF, m_enc(8'hFF) ^ 12'h804, "R6");
    check("R6", "syn15 passthrough", 32'(dec_msg_o), 32'h7E);
    idle_check();

    // Extremes of the message space, clean words (R4).
    step(8'h00, m_enc(8'h00), "R4");
    step(8'hFF, m_enc(8'hFF), "R4");

    // Random messages with no error or one random error position.
    for (int n = 0; n < 300; n++) begin
      logic [7:0]  m;
      int          e;
      m = 8'($urandom);
      e = int'($urandom_range(0, 12));
      base = m_enc(m);
      if (e != 0) base[e-1] = ~base[e-1];
      step(m, base, (e == 0) ? "R4" : "R5");
      check((e == 0) ? "R4" : "R5", "random roundtrip", 32'(dec_msg_o), 32'(m));
      if ((n % 37) == 0) idle_check();
    end

    // Reset in the middle of traffic (R8).
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8", "mid reset valids", 32'({enc_valid_o, dec_valid_o}), 32'd0);
    check("R8", "mid reset data", 32'({enc_code_o, dec_msg_o, dec_fixed_o, dec_bad_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule